// File: doc/BRIEF.md
# Exception Return Decoder

This block watches every write to the program counter and sorts it into one of three outcomes. If the value is an ordinary branch target, the write is a branch. If the value carries the exception-return prefix (every bit above the low nibble set) and the core is running a handler, the write is a request to leave the exception. In that case the low nibble selects the stack that the saved state is restored from, the mode to run in afterwards, and the stack pointer to use afterwards. A prefixed value whose low nibble is not one of the three legal codes raises a fault request instead.

The core supplies a write strobe, the 32-bit value and its current mode. The block produces single-cycle pulses for branch, return start and fault. It also holds registered copies of the post-return mode, the active stack pointer select and the restore stack. A separate sequencer performs the actual unstacking from memory, triggered by the return-start pulse.

Top module: `excret_decode_unit`

## Requirements
- R1: While `rst_n` is low, the next clock edge clears all three pulses, sets `mode_handler_o` to 0 (Thread), and sets `sp_proc_o` and `restore_psp_o` to 0 (main stack).
- R2: A write of 0xFFFFFFF1 while `in_handler_i`=1 raises `ret_start_o` one cycle after the sampling edge. On that same edge it sets `mode_handler_o`=1, `sp_proc_o`=0 and `restore_psp_o`=0.
- R3: A write of 0xFFFFFFF9 while `in_handler_i`=1 raises `ret_start_o` one cycle after the sampling edge. On that same edge it sets `mode_handler_o`=0, `sp_proc_o`=0 and `restore_psp_o`=0.
- R4: A write of 0xFFFFFFFD while `in_handler_i`=1 raises `ret_start_o` one cycle after the sampling edge. On that same edge it sets `mode_handler_o`=0, `sp_proc_o`=1 and `restore_psp_o`=1.
- R5: A write in Handler mode whose bits [31:4] are all ones and whose low nibble is not 0x1, 0x9 or 0xD raises `fault_o` for one cycle. It raises no `ret_start_o` and leaves `mode_handler_o`, `sp_proc_o` and `restore_psp_o` unchanged.
- R6: A write while `in_handler_i`=0 is always a branch, whatever the value. It raises `branch_o` only and leaves the three state outputs unchanged.
- R7: A write in Handler mode whose bits [31:4] are not all ones raises `branch_o` only and leaves the three state outputs unchanged.
- R8: Each pulse lasts one cycle per write. A cycle without `pc_wr_i` produces no pulse in the following cycle.
- R9: Each write produces exactly one of `branch_o`, `ret_start_o` and `fault_o`, never two at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_wr_i | input | 1 | Program counter write strobe |
| pc_val_i | input | 32 | Value written to the program counter |
| in_handler_i | input | 1 | Current mode of the core: 1 = Handler, 0 = Thread |
| branch_o | output | 1 | One-cycle pulse: the write was an ordinary branch |
| ret_start_o | output | 1 | One-cycle pulse: exception return sequence starts |
| fault_o | output | 1 | One-cycle pulse: reserved return value seen |
| restore_psp_o | output | 1 | Stack to restore state from: 1 = process, 0 = main |
| mode_handler_o | output | 1 | Mode after the last return: 1 = Handler, 0 = Thread |
| sp_proc_o | output | 1 | Active stack pointer after the last return: 1 = process, 0 = main |

## Verification
The three legal return codes are each written in Handler mode, which shows that every code maps to its own mode and stack combination. All sixteen prefixed nibbles are also swept in Handler mode, which separates the three legal codes from the thirteen reserved ones. The same prefixed values are replayed in Thread mode to show that mode gating turns them into branches. Near-miss values with a single prefix bit cleared, back-to-back returns and idle gaps show that only the exact prefix is decoded and that each write makes exactly one pulse.

// File: rtl/excret_pkg.sv
// Package: shared types and return-code constants for the exception
// return decoder. Assumes a 4-bit code field at the bottom of the value.
package excret_pkg;

    localparam int CODE_W = 4;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } cpu_mode_e;

    typedef enum logic {
        STK_MAIN = 1'b0,
        STK_PROC = 1'b1
    } stack_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_BRANCH = 2'd1,
        EV_RETURN = 2'd2,
        EV_FAULT  = 2'd3
    } pc_event_e;

    typedef struct packed {
        logic      legal;
        stack_e    restore;
        cpu_mode_e mode;
        stack_e    sp;
    } ret_plan_t;

    localparam logic [CODE_W-1:0] CODE_HANDLER_MAIN = 4'h1;
    localparam logic [CODE_W-1:0] CODE_THREAD_MAIN  = 4'h9;
    localparam logic [CODE_W-1:0] CODE_THREAD_PROC  = 4'hD;

endpackage

// File: rtl/excret_prefix_match.sv
// Module: excret_prefix_match
// Purpose: splits a program counter value into its prefix and code field
// and reports whether every prefix bit is set.
// Assumes: DATA_W > CODE_W; the prefix is all ones by definition.
module excret_prefix_match
    import excret_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value_i,
    output logic              prefix_hit_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int PREFIX_W = DATA_W - CODE_W;

    logic [PREFIX_W-1:0] prefix_bits;
    logic [PREFIX_W-1:0] prefix_and;

    // Separate prefix and code field.
    always_comb begin
        prefix_bits = value_i[DATA_W-1:CODE_W];
        code_o      = value_i[CODE_W-1:0];
    end

    // AND chain across the prefix, one stage per bit.
    assign prefix_and[0] = prefix_bits[0];
    for (genvar g = 1; g < PREFIX_W; g++) begin : g_and_chain
        assign prefix_and[g] = prefix_and[g-1] & prefix_bits[g];
    end

    assign prefix_hit_o = prefix_and[PREFIX_W-1];

endmodule

// File: rtl/excret_code_decode.sv
// Module: excret_code_decode
// Purpose: maps the code field of a return value to a restore stack,
// post-return mode and post-return stack pointer.
// Assumes: codes other than the three legal ones are reserved.
module excret_code_decode
    import excret_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output ret_plan_t         plan_o
);
    // Table lookup of the return plan for this code.
    always_comb begin
        plan_o = '{legal: 1'b0, restore: STK_MAIN, mode: MODE_THREAD, sp: STK_MAIN};
        unique case (code_i)
            CODE_HANDLER_MAIN:
                plan_o = '{legal: 1'b1, restore: STK_MAIN, mode: MODE_HANDLER, sp: STK_MAIN};
            CODE_THREAD_MAIN:
                plan_o = '{legal: 1'b1, restore: STK_MAIN, mode: MODE_THREAD,  sp: STK_MAIN};
            CODE_THREAD_PROC:
                plan_o = '{legal: 1'b1, restore: STK_PROC, mode: MODE_THREAD,  sp: STK_PROC};
            default: ;
        endcase
    end

endmodule

// File: rtl/excret_state_regs.sv
// Module: excret_state_regs
// Purpose: holds the event pulses and the mode, stack-select and restore
// registers; state changes only on a legal return.
// Assumes: one event per cycle from the classifier; synchronous active-low reset.
module excret_state_regs
    import excret_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pc_event_e event_i,
    input  ret_plan_t plan_i,
    output logic      branch_o,
    output logic      ret_start_o,
    output logic      fault_o,
    output stack_e    restore_o,
    output cpu_mode_e mode_o,
    output stack_e    sp_o
);
    // Register one-cycle pulses from the event of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            branch_o    <= 1'b0;
            ret_start_o <= 1'b0;
            fault_o     <= 1'b0;
        end else begin
            branch_o    <= (event_i == EV_BRANCH);
            ret_start_o <= (event_i == EV_RETURN);
            fault_o     <= (event_i == EV_FAULT);
        end
    end

    // Load mode, stack select and restore stack on a legal return only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o    <= MODE_THREAD;
            sp_o      <= STK_MAIN;
            restore_o <= STK_MAIN;
        end else if (event_i == EV_RETURN) begin
            mode_o    <= plan_i.mode;
            sp_o      <= plan_i.sp;
            restore_o <= plan_i.restore;
        end
    end

    // R9: at most one pulse per cycle.
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({branch_o, ret_start_o, fault_o}));

    // R5: a fault leaves the state registers untouched.
    p_fault_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(mode_o) && $stable(sp_o) && $stable(restore_o)));

    // R4: the process stack is only ever chosen together with Thread mode.
    p_proc_thread_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_o == STK_PROC) |-> (mode_o == MODE_THREAD));

    // R6: branches never move the state registers.
    p_branch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> ($stable(mode_o) && $stable(sp_o)));

endmodule

// File: rtl/excret_decode_unit.sv
// Module: excret_decode_unit (top)
// Purpose: classifies program counter writes as branch, exception return
// or reserved-value fault, and tracks post-return mode and stack pointer.
// Assumes: in_handler_i reflects the core's mode in the cycle of the write;
// the unstacking itself is done elsewhere, triggered by ret_start_o.
module excret_decode_unit
    import excret_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_wr_i,
    input  logic [DATA_W-1:0] pc_val_i,
    input  logic              in_handler_i,
    output logic              branch_o,
    output logic              ret_start_o,
    output logic              fault_o,
    output logic              restore_psp_o,
    output logic              mode_handler_o,
    output logic              sp_proc_o
);
    logic              prefix_hit;
    logic [CODE_W-1:0] code;
    ret_plan_t         plan;
    pc_event_e         pc_event;
    stack_e            restore_q;
    cpu_mode_e         mode_q;
    stack_e            sp_q;

    excret_prefix_match #(.DATA_W(DATA_W)) u_match (
        .value_i      (pc_val_i),
        .prefix_hit_o (prefix_hit),
        .code_o       (code)
    );

    excret_code_decode u_decode (
        .code_i (code),
        .plan_o (plan)
    );

    // Classify this cycle's write; pattern decoding only in Handler mode.
    always_comb begin
        if (!pc_wr_i)
            pc_event = EV_NONE;
        else if (!in_handler_i || !prefix_hit)
            pc_event = EV_BRANCH;
        else if (plan.legal)
            pc_event = EV_RETURN;
        else
            pc_event = EV_FAULT;
    end

    excret_state_regs u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_i     (pc_event),
        .plan_i      (plan),
        .branch_o    (branch_o),
        .ret_start_o (ret_start_o),
        .fault_o     (fault_o),
        .restore_o   (restore_q),
        .mode_o      (mode_q),
        .sp_o        (sp_q)
    );

    // Expose enum state as plain bits.
    always_comb begin
        restore_psp_o  = (restore_q == STK_PROC);
        mode_handler_o = (mode_q == MODE_HANDLER);
        sp_proc_o      = (sp_q == STK_PROC);
    end

    // R8: no pulse without a write in the previous cycle.
    p_pulse_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_o || ret_start_o || fault_o) |-> $past(pc_wr_i));

    // R9: every write produces a pulse in the next cycle.
    p_write_gives_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_i |=> (branch_o || ret_start_o || fault_o));

    // R6: a write in Thread mode is never a return or fault.
    p_thread_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_i && !in_handler_i) |=> (branch_o && !ret_start_o && !fault_o));

    // R1: reset leaves Thread mode on the main stack.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!mode_handler_o && !sp_proc_o && !restore_psp_o && !ret_start_o));

endmodule

// File: tb/excret_decode_unit_tb_top.sv
module excret_decode_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_wr_i = 1'b0;
    logic [31:0] pc_val_i = '0;
    logic        in_handler_i = 1'b0;
    logic        branch_o, ret_start_o, fault_o;
    logic        restore_psp_o, mode_handler_o, sp_proc_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference state
    int m_branch, m_ret, m_fault, m_restore, m_mode, m_sp;

    always #4 clk = ~clk; // 125 MHz

    excret_decode_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_wr_i(pc_wr_i), .pc_val_i(pc_val_i),
        .in_handler_i(in_handler_i), .branch_o(branch_o), .ret_start_o(ret_start_o),
        .fault_o(fault_o), .restore_psp_o(restore_psp_o),
        .mode_handler_o(mode_handler_o), .sp_proc_o(sp_proc_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL R8 watchdog: actual %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(string req, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, name, act, exp);
        end
    endtask

    // Behavioural reference for one sampled edge.
    task automatic model(bit wr, logic [31:0] v, bit hand, output string req);
        m_branch = 0; m_ret = 0; m_fault = 0;
        if (!wr) req = "R8";
        else if (!hand) begin req = "R6"; m_branch = 1; end
        else if (v[31:4] != 28'hFFFFFFF) begin req = "R7"; m_branch = 1; end
        else if (v[3:0] == 4'h1) begin req = "R2"; m_ret = 1; m_mode = 1; m_sp = 0; m_restore = 0; end
        else if (v[3:0] == 4'h9) begin req = "R3"; m_ret = 1; m_mode = 0; m_sp = 0; m_restore = 0; end
        else if (v[3:0] == 4'hD) begin req = "R4"; m_ret = 1; m_mode = 0; m_sp = 1; m_restore = 1; end
        else begin req = "R5"; m_fault = 1; end
    endtask

    task automatic step(bit wr, logic [31:0] v, bit hand);
        string req;
        pc_wr_i = wr; pc_val_i = v; in_handler_i = hand;
        @(posedge clk);
        model(wr, v, hand, req);
        @(negedge clk);
        check(req, "branch_o", int'(branch_o), m_branch);
        check(req, "ret_start_o", int'(ret_start_o), m_ret);
        check(req, "fault_o", int'(fault_o), m_fault);
        check(req, "mode_handler_o", int'(mode_handler_o), m_mode);
        check(req, "sp_proc_o", int'(sp_proc_o), m_sp);
        check(req, "restore_psp_o", int'(restore_psp_o), m_restore);
        check("R9", "pulse count", int'(branch_o) + int'(ret_start_o) + int'(fault_o), wr ? 1 : 0);
    endtask

    initial begin
        // R1: reset with noisy inputs
        pc_wr_i = 1'b1; pc_val_i = 32'hFFFFFFFD; in_handler_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ret_start_o", int'(ret_start_o), 0);
        check("R1", "branch_o", int'(branch_o), 0);
        check("R1", "fault_o", int'(fault_o), 0);
        check("R1", "mode_handler_o", int'(mode_handler_o), 0);
        check("R1", "sp_proc_o", int'(sp_proc_o), 0);
        check("R1", "restore_psp_o", int'(restore_psp_o), 0);
        pc_wr_i = 1'b0;
        m_mode = 0; m_sp = 0; m_restore = 0;
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 32'h0, 0);
        // R6: Thread-mode writes, including prefixed values
        step(1, 32'h0800_0100, 0);
        step(1, 32'hFFFFFFFD, 0);
        step(1, 32'hFFFFFFF1, 0);
        // R4 then R2 then R3, back to back
        step(1, 32'hFFFFFFFD, 1);
        step(1, 32'hFFFFFFF1, 1);
        step(1, 32'hFFFFFFF9, 1);
        step(0, 32'hFFFFFFFD, 1); // R8 idle with value present
        // Sweep all codes in Handler mode (R5 for reserved) after setting PSP
        for (int n = 0; n < 16; n++) begin
            step(1, 32'hFFFFFFFD, 1);
            step(1, {28'hFFFFFFF, 4'(n)}, 1);
            step(0, 32'h0, 1);
        end
        // R7: near misses, one prefix bit cleared
        for (int b = 4; b < 32; b++) begin
            step(1, 32'hFFFFFFFD & ~(32'h1 << b), 1);
        end
        step(1, 32'h0000_0001, 1);
        // R6: full prefixed sweep in Thread mode after an R2 return
        step(1, 32'hFFFFFFF1, 1);
        for (int n = 0; n < 16; n++) begin
            step(1, {28'hFFFFFFF, 4'(n)}, 0);
        end
        step(0, 32'h0, 0);
        step(0, 32'h0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule